// File: doc/BRIEF.md
# Serial Engine Command Bridge

This block sits between a processor's register bus and a serial interface engine that takes byte-wide commands. Software writes a 32-bit command word. Bits 15:8 of that word give a phase code, and bits 23:16 give one byte. That byte is a command code in the Command and Read phases and a data byte in the Write phase. The bridge keeps the accepted word and offers it to the engine as a request that it holds until the engine takes it.

When the engine takes a Command or Write phase, the bridge raises a done flag. When it takes a Read phase, the bridge waits for the engine's response strobe. It then stores the returned byte in a read-only data register and raises a data-full flag, which also drives the interrupt output.

Both flags are cleared by writing 1 to their bits in a clear register. Software issues a phase, waits for the matching flag, and then issues the next phase.

Top module: `sie_cmd_bridge`

## Requirements
- R1: After reset, the command readback, the data register, both flags, `irq_o` and `eng_req_valid` are all zero.
- R2: A bus write to address 0 with a known phase stores bits 15:8 as the phase and bits 23:16 as the byte. Address 0 then reads back `{8'h00, byte, phase, 8'h00}`, so the reserved bits 7:0 and 31:24 are dropped. `eng_req_valid` is high on the cycle after the write, carrying that phase and byte.
- R3: The known phase codes are 0x05 (Command), 0x01 (Read) and 0x02 (Write). A write to address 0 with any other phase value raises no request and leaves the address 0 readback unchanged.
- R4: While `eng_req_valid` is high and `eng_req_ready` is low, the request stays valid and its phase and byte stay stable.
- R5: When the engine accepts a Command or Write phase, status bit 0 (done) reads 1 on the following cycle. The status register is at address 2.
- R6: When the engine accepts a Read phase, no done flag is raised and the bridge waits for `eng_rsp_valid`. The next cycle after that strobe, address 1 reads `{24'h0, eng_rsp_data}`, status bit 1 (full) is 1 and `irq_o` is high.
- R7: A write to address 0 while a request is pending or a Read response is awaited is ignored. The held request and the readback are not changed.
- R8: `eng_rsp_valid` is ignored unless a Read response is awaited. The data register and the full flag are left unchanged.
- R9: Writing to address 3 clears a flag for each 1 in bits 1:0, matching the status bit positions; 0 bits leave their flag alone. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 command, 1 data, 2 status, 3 clear) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| eng_req_valid | output | 1 | Request to the engine is valid |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_req_phase | output | 8 | Phase code of the request |
| eng_req_byte | output | 8 | Command code or write data byte |
| eng_rsp_valid | input | 1 | Engine response strobe |
| eng_rsp_data | input | 8 | Byte returned for a Read phase |
| irq_o | output | 1 | Data-full interrupt, equal to the full flag |

## Verification
A command write is registered once, so `eng_req_valid` and the readback are due on the first falling edge after the write's rising edge. The done flag follows the accepting edge by one register. The data byte and the full flag follow the response edge by one register. The bench drives every input on a falling edge and samples on the next falling edge, so each result is read exactly one register stage after the edge that causes it. All 256 phase values are swept. Hold, busy and set-versus-clear collisions are each aligned to a single edge.

// File: rtl/sie_cmd_pkg.sv
package sie_cmd_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int RADDR_W = 2;

    localparam logic [BYTE_W-1:0] PH_READ  = 8'h01;
    localparam logic [BYTE_W-1:0] PH_WRITE = 8'h02;
    localparam logic [BYTE_W-1:0] PH_CMD   = 8'h05;

    localparam logic [RADDR_W-1:0] RA_CMD   = 2'd0;
    localparam logic [RADDR_W-1:0] RA_RDATA = 2'd1;
    localparam logic [RADDR_W-1:0] RA_STAT  = 2'd2;
    localparam logic [RADDR_W-1:0] RA_CLR   = 2'd3;

    localparam int FLAG_DONE = 0;
    localparam int FLAG_FULL = 1;
    localparam int NUM_FLAGS = 2;

    typedef struct packed {
        logic [BYTE_W-1:0] payload;
        logic [BYTE_W-1:0] phase;
    } eng_req_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    function automatic logic phase_known(input logic [BYTE_W-1:0] p);
        return (p == PH_READ) || (p == PH_WRITE) || (p == PH_CMD);
    endfunction

    function automatic logic phase_wants_rsp(input logic [BYTE_W-1:0] p);
        return p == PH_READ;
    endfunction

endpackage

// File: rtl/sie_cmd_decode.sv
module sie_cmd_decode
    import sie_cmd_pkg::*;
#(
    parameter int W_W = WORD_W,
    parameter int B_W = BYTE_W,
    parameter int A_W = RADDR_W,
    parameter int F_N = NUM_FLAGS
) (
    input  logic           wr,
    input  logic [A_W-1:0] addr,
    input  logic [W_W-1:0] wdata,
    input  logic           busy,
    output logic           issue,
    output eng_req_t       req,
    output logic [F_N-1:0] clr_mask
);
    localparam int PH_LSB = B_W;
    localparam int PL_LSB = 2 * B_W;

    logic unused_rsvd;
    assign unused_rsvd = ^{wdata[W_W-1:PL_LSB+B_W], wdata[PH_LSB-1:F_N]};

    always_comb begin
        req.phase   = wdata[PH_LSB +: B_W];
        req.payload = wdata[PL_LSB +: B_W];
        issue       = wr && (addr == RA_CMD) && !busy && phase_known(req.phase);
        clr_mask    = (wr && (addr == RA_CLR)) ? wdata[F_N-1:0] : '0;
    end

endmodule

// File: rtl/sie_cmd_seq.sv
module sie_cmd_seq
    import sie_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     issue,
    input  eng_req_t req_in,
    output eng_req_t req_q,
    output logic     eng_req_valid,
    input  logic     eng_req_ready,
    input  logic     eng_rsp_valid,
    output logic     busy,
    output logic     done_pulse,
    output logic     rsp_pulse
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (issue) begin
                    req_q <= req_in;
                    state <= ST_REQ;
                end
                ST_REQ: if (eng_req_ready) begin
                    state <= phase_wants_rsp(req_q.phase) ? ST_WAIT : ST_IDLE;
                end
                ST_WAIT: if (eng_rsp_valid) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign eng_req_valid = (state == ST_REQ);
    assign busy          = (state != ST_IDLE);
    assign done_pulse    = (state == ST_REQ) && eng_req_ready && !phase_wants_rsp(req_q.phase);
    assign rsp_pulse     = (state == ST_WAIT) && eng_rsp_valid;

    // R4: pending request is held stable until taken
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        eng_req_valid && !eng_req_ready |=> eng_req_valid && $stable(req_q));

    // R7: a busy sequencer never reloads its request
    a_r7_busy_keeps_req: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(req_q));

    a_r4_state_legal: assert property (@(posedge clk) disable iff (rst)
        $onehot0({state == ST_REQ, state == ST_WAIT}) && state != 2'd3);

endmodule

// File: rtl/sie_cmd_flags.sv
module sie_cmd_flags
    import sie_cmd_pkg::*;
#(
    parameter int B_W = BYTE_W,
    parameter int F_N = NUM_FLAGS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           set_done,
    input  logic           set_full,
    input  logic [B_W-1:0] rsp_byte,
    input  logic [F_N-1:0] clr_mask,
    output logic [F_N-1:0] flags_q,
    output logic [B_W-1:0] rdata_q
);
    logic [F_N-1:0] set_vec;

    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_DONE] = set_done;
        set_vec[FLAG_FULL] = set_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            rdata_q <= '0;
        end else begin
            flags_q <= set_vec | (flags_q & ~clr_mask);
            if (set_full) rdata_q <= rsp_byte;
        end
    end

    // R6: response byte lands with the full flag
    a_r6_full_capture: assert property (@(posedge clk) disable iff (rst)
        set_full |=> flags_q[FLAG_FULL] && rdata_q == $past(rsp_byte));

    // R9: set beats clear in the same cycle
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_done && clr_mask[FLAG_DONE] |=> flags_q[FLAG_DONE]);

    // R8: data register only moves on a captured response
    a_r8_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
        !set_full |=> $stable(rdata_q));

endmodule

// File: rtl/sie_cmd_bridge.sv
module sie_cmd_bridge
    import sie_cmd_pkg::*;
#(
    parameter int W_W = WORD_W,
    parameter int B_W = BYTE_W,
    parameter int A_W = RADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [A_W-1:0] bus_addr,
    input  logic [W_W-1:0] bus_wdata,
    output logic [W_W-1:0] bus_rdata,
    output logic           eng_req_valid,
    input  logic           eng_req_ready,
    output logic [B_W-1:0] eng_req_phase,
    output logic [B_W-1:0] eng_req_byte,
    input  logic           eng_rsp_valid,
    input  logic [B_W-1:0] eng_rsp_data,
    output logic           irq_o
);
    localparam int F_N = NUM_FLAGS;

    logic           issue, busy, done_pulse, rsp_pulse;
    eng_req_t       req_dec, req_q;
    logic [F_N-1:0] clr_mask, flags_q;
    logic [B_W-1:0] rdata_q;

    sie_cmd_decode #(.W_W(W_W), .B_W(B_W), .A_W(A_W), .F_N(F_N)) u_dec (
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .busy(busy),
        .issue(issue), .req(req_dec), .clr_mask(clr_mask)
    );

    sie_cmd_seq u_seq (
        .clk(clk), .rst(rst), .issue(issue), .req_in(req_dec), .req_q(req_q),
        .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
        .eng_rsp_valid(eng_rsp_valid), .busy(busy),
        .done_pulse(done_pulse), .rsp_pulse(rsp_pulse)
    );

    sie_cmd_flags #(.B_W(B_W), .F_N(F_N)) u_flags (
        .clk(clk), .rst(rst), .set_done(done_pulse), .set_full(rsp_pulse),
        .rsp_byte(eng_rsp_data), .clr_mask(clr_mask),
        .flags_q(flags_q), .rdata_q(rdata_q)
    );

    assign eng_req_phase = req_q.phase;
    assign eng_req_byte  = req_q.payload;
    assign irq_o         = flags_q[FLAG_FULL];

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            RA_CMD:   bus_rdata[3*B_W-1:B_W] = {req_q.payload, req_q.phase};
            RA_RDATA: bus_rdata[B_W-1:0]     = rdata_q;
            RA_STAT:  bus_rdata[F_N-1:0]     = flags_q;
            default:  bus_rdata              = '0;
        endcase
    end

    // R3: unknown phase from idle raises no request
    a_r3_bad_phase: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == RA_CMD && !busy && !phase_known(bus_wdata[2*B_W-1:B_W])
        |=> !eng_req_valid);

    // R2: known phase from idle raises the request with its fields
    a_r2_issue: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == RA_CMD && !busy && phase_known(bus_wdata[2*B_W-1:B_W])
        |=> eng_req_valid && eng_req_phase == $past(bus_wdata[2*B_W-1:B_W])
            && eng_req_byte == $past(bus_wdata[3*B_W-1:2*B_W]));

    // R5: accepted non-read phase sets done
    a_r5_done: assert property (@(posedge clk) disable iff (rst)
        eng_req_valid && eng_req_ready && eng_req_phase != PH_READ |=> flags_q[FLAG_DONE]);

    // R8: stray response while idle leaves full alone
    a_r8_stray_rsp: assert property (@(posedge clk) disable iff (rst)
        !busy && eng_rsp_valid && !(bus_wr && bus_addr == RA_CLR) |=> $stable(flags_q[FLAG_FULL]));

endmodule

// File: tb/test_sie_cmd_bridge.sv
module test_sie_cmd_bridge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst = 1;
    logic        bus_wr = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        eng_req_valid, eng_req_ready = 0;
    logic [7:0]  eng_req_phase, eng_req_byte;
    logic        eng_rsp_valid = 0;
    logic [7:0]  eng_rsp_data = 0;
    logic        irq_o;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sie_cmd_bridge i_sie_cmd_bridge (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
        .eng_req_phase(eng_req_phase), .eng_req_byte(eng_req_byte),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp_data(eng_rsp_data), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic pulse_ready();
        eng_req_ready = 1;
        @(negedge clk);
        eng_req_ready = 0;
    endtask

    task automatic pulse_rsp(input logic [7:0] d);
        eng_rsp_valid = 1; eng_rsp_data = d;
        @(negedge clk);
        eng_rsp_valid = 0;
    endtask

    function automatic logic [31:0] word(input logic [7:0] b, input logic [7:0] p);
        return {8'hA5, b, p, 8'h5A};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, exp_cmd;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(0, v); eq("R1", "cmd readback", v, 0);
        rd(1, v); eq("R1", "read data", v, 0);
        rd(2, v); eq("R1", "status", v, 0);
        eq("R1", "req_valid", eng_req_valid, 0);
        eq("R1", "irq", irq_o, 0);

        // R2/R3/R5/R6 sweep over every phase value
        exp_cmd = 0;
        for (int p = 0; p < 256; p++) begin
            logic [7:0] ph, b;
            bit known;
            ph = p[7:0];
            b = ph ^ 8'h3C;
            known = (ph == 8'h01) || (ph == 8'h02) || (ph == 8'h05);
            wr(0, word(b, ph));
            eq("R3", "req_valid vs phase", eng_req_valid, known);
            if (known) begin
                exp_cmd = {8'h00, b, ph, 8'h00};
                eq("R2", "req phase", eng_req_phase, ph);
                eq("R2", "req byte", eng_req_byte, b);
                rd(0, v); eq("R2", "cmd readback", v, exp_cmd);
                pulse_ready();
                eq("R2", "valid drops after accept", eng_req_valid, 0);
                if (ph == 8'h01) begin
                    rd(2, v); eq("R6", "no done on read", v, 0);
                    pulse_rsp(~b);
                    rd(1, v); eq("R6", "read data", v, {24'h0, ~b});
                    rd(2, v); eq("R6", "full flag", v, 2);
                    eq("R6", "irq", irq_o, 1);
                end else begin
                    rd(2, v); eq("R5", "done flag", v, 1);
                    eq("R5", "irq stays low", irq_o, 0);
                end
                wr(3, 32'h3);
                rd(2, v); eq("R9", "cleared", v, 0);
            end else begin
                rd(0, v); eq("R3", "ignored readback", v, exp_cmd);
                rd(2, v); eq("R3", "no flag", v, 0);
            end
        end

        // R4 hold while not ready, R7 write while pending
        wr(0, word(8'h77, 8'h05));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            eq("R4", "held valid", eng_req_valid, 1);
            eq("R4", "held phase", eng_req_phase, 8'h05);
            eq("R4", "held byte", eng_req_byte, 8'h77);
        end
        wr(0, word(8'h11, 8'h02));
        eq("R7", "pending byte kept", eng_req_byte, 8'h77);
        rd(0, v); eq("R7", "pending readback kept", v, 32'h0077_0500);
        pulse_ready();
        rd(2, v); eq("R5", "done after hold", v, 1);
        eq("R7", "no second request", eng_req_valid, 0);
        wr(3, 32'h1);

        // R7 write while awaiting response
        wr(0, word(8'h40, 8'h01));
        pulse_ready();
        wr(0, word(8'h99, 8'h05));
        eq("R7", "no request while waiting", eng_req_valid, 0);
        rd(0, v); eq("R7", "wait readback kept", v, 32'h0040_0100);
        pulse_rsp(8'hC3);
        rd(1, v); eq("R6", "read data C3", v, 32'hC3);
        eq("R7", "still idle", eng_req_valid, 0);
        wr(3, 32'h3);

        // R8 stray response
        @(negedge clk);
        pulse_rsp(8'h12);
        rd(1, v); eq("R8", "data unchanged", v, 32'hC3);
        rd(2, v); eq("R8", "full not set", v, 0);

        // R9 partial clears
        wr(0, word(8'h21, 8'h05));
        pulse_ready();
        wr(0, word(8'h22, 8'h01));
        pulse_ready();
        pulse_rsp(8'h6A);
        rd(2, v); eq("R9", "both set", v, 3);
        wr(3, 32'h1);
        rd(2, v); eq("R9", "clear done only", v, 2);
        wr(3, 32'h0);
        rd(2, v); eq("R9", "zero clears nothing", v, 2);
        wr(3, 32'h2);
        rd(2, v); eq("R9", "clear full", v, 0);
        eq("R9", "irq cleared", irq_o, 0);

        // R9 set and clear on the same edge
        wr(0, word(8'h23, 8'h01));
        pulse_ready();
        bus_wr = 1; bus_addr = 3; bus_wdata = 32'h2;
        eng_rsp_valid = 1; eng_rsp_data = 8'h5E;
        @(negedge clk);
        bus_wr = 0; eng_rsp_valid = 0;
        rd(2, v); eq("R9", "set wins over clear", v, 2);
        rd(1, v); eq("R6", "collision data", v, 32'h5E);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule